// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the 32-bit status and control word of a floating-point unit. The word contains sticky exception flags, per-class trap enables, result-class bits, a non-IEEE mode bit and a two-bit rounding-mode field. Each cycle the unit can take an exception report from the FPU result port. In the same cycle it can take one software operation. The operations are:

- a masked write of whole 4-bit fields from a data word;
- a 4-bit immediate write into one field;
- a single-bit clear;
- a single-bit set;
- a copy-out that returns one field and then clears the exception bits in that field.

Three summary bits are kept up to date:

- any-new-exception: sticky, and settable by software;
- any-invalid-operation: a pure OR that software cannot write;
- any-enabled-exception: a pure OR that software cannot write.

A registered request output follows the enabled-exception summary, so the core can take a precise trap. Bit positions are numbered 0 to 31 with position 0 as the most significant. On `csr_o`, position p is bit 31-p. Field k covers positions 4k to 4k+3.

Top module: `fp_status_ctl`

## Requirements
- R1: After reset, `csr_o` reads zero, and `exc_req` and `rd_valid` are low.
- R2: When `fpu_valid` is high, each `fpu_flags` bit that lies on a sticky-flag position is ORed into the word. The sticky-flag positions are: 3 overflow, 4 underflow, 5 divide-by-zero, 6 inexact, and 7–12 and 21–23 invalid-operation sub-flags. In the same report, position 13 takes `fpu_fr`, position 14 takes `fpu_fi`, and positions 15–19 take `fpu_class`, with `fpu_class[4]` at position 15. The new value is visible one cycle later.
- R3: Position 0 is sticky. It is set when a report turns at least one sticky flag from 0 to 1. A report of a flag that is already 1 does not set it.
- R4: Position 2 always equals the OR of the invalid sub-flags at positions 7–12 and 21–23.
- R5: Position 1 always equals the OR of five products: overflow·pos25, underflow·pos26, divide-by-zero·pos27, inexact·pos28, and position 2·pos24. `exc_req` equals position 1 at every cycle.
- R6: `sw_op`=0 copies every field k whose `sw_mask[k]` is 1 from the same positions of `sw_data`.
- R7: `sw_op`=1 writes `sw_imm` into field `sw_fsel`, with `sw_imm[3]` at the lowest-numbered position.
- R8: `sw_op`=2 clears position `sw_pos` and `sw_op`=3 sets it. These writes, and the field writes, can change position 0. They have no effect on positions 1, 2 and 20; position 20 always reads zero. Codes 5–7 change nothing.
- R9: `sw_op`=4 presents field `sw_fsel` as it was before the operation on `rd_data`, with `rd_valid` high for one cycle. It clears positions 0, 3–12 and 21–23 inside that field and leaves every other bit unchanged.
- R10: When software and the FPU act in the same cycle, the software operation is applied first. The FPU report is applied to its result, and the summaries are computed from the final value.
- R11: A sticky flag, or position 0, that is set stays set in every cycle without a software operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_valid | input | 1 | FPU result report this cycle |
| fpu_flags | input | 32 | Raised exception flags, in the same layout as `csr_o` |
| fpu_class | input | 5 | Result-class code for positions 15–19 |
| fpu_fr | input | 1 | Fraction-rounded status for position 13 |
| fpu_fi | input | 1 | Fraction-inexact status for position 14 |
| sw_valid | input | 1 | Software operation this cycle |
| sw_op | input | 3 | Operation code (0 fields, 1 immediate, 2 clear, 3 set, 4 copy-out) |
| sw_mask | input | 8 | Field select for the masked write; bit k selects field k |
| sw_data | input | 32 | Data word for the masked write |
| sw_fsel | input | 3 | Field index for immediate write and copy-out |
| sw_imm | input | 4 | Immediate field value |
| sw_pos | input | 5 | Bit position for clear and set |
| csr_o | output | 32 | Current register word; bit 31-p holds position p |
| exc_req | output | 1 | Enabled-exception request |
| rd_valid | output | 1 | Copy-out result valid |
| rd_data | output | 4 | Field returned by copy-out |

## Verification
Most state errors show on `csr_o` one cycle after the operation that causes them, because the whole word is visible at the port. A lost sticky update, or a summary computed from the wrong intermediate value, therefore appears at once. An error in the enabled-exception path is the exception: while the enables are zero it stays invisible. Enabling a class exposes it one cycle later through position 1 and `exc_req`. A flag wrongly counted as new shows up only after position 0 has been cleared on its own, so the bench clears that bit alone and then repeats the report.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int CSR_W  = 32;
  localparam int FLD_W  = 4;
  localparam int N_FLD  = CSR_W / FLD_W;
  localparam int CLS_W  = 5;
  localparam int POS_W  = $clog2(CSR_W);
  localparam int FSEL_W = $clog2(N_FLD);

  typedef enum logic [2:0] {
    OP_FIELDS = 3'd0,
    OP_IMM    = 3'd1,
    OP_CLR    = 3'd2,
    OP_SET    = 3'd3,
    OP_COPY   = 3'd4
  } sw_op_e;

  // Bit indices into the stored word (position p lives at index 31-p).
  localparam int B_ANY = 31;
  localparam int B_EN  = 30;
  localparam int B_INV = 29;
  localparam int B_OVF = 28;
  localparam int B_UNF = 27;
  localparam int B_DZ  = 26;
  localparam int B_INX = 25;
  localparam int B_FR  = 18;
  localparam int B_FI  = 17;
  localparam int B_CLS = 16;
  localparam int B_RSV = 11;
  localparam int B_VE  = 7;
  localparam int B_OE  = 6;
  localparam int B_UE  = 5;
  localparam int B_ZE  = 4;
  localparam int B_XE  = 3;

  localparam logic [CSR_W-1:0] TOP_BIT   = {1'b1, {(CSR_W-1){1'b0}}};
  localparam logic [CSR_W-1:0] TOP_FIELD = {{FLD_W{1'b1}}, {(CSR_W-FLD_W){1'b0}}};
  localparam logic [CSR_W-1:0] M_STICKY  = 32'h1FF8_0700;
  localparam logic [CSR_W-1:0] M_INV     = 32'h01F8_0700;
  localparam logic [CSR_W-1:0] M_CLEAR   = M_STICKY | TOP_BIT;

  function automatic logic inv_summary(input logic [CSR_W-1:0] v);
    return |(v & M_INV);
  endfunction

  function automatic logic en_summary(input logic [CSR_W-1:0] v);
    return (v[B_OVF] & v[B_OE]) | (v[B_UNF] & v[B_UE]) |
           (v[B_DZ] & v[B_ZE]) | (v[B_INX] & v[B_XE]) |
           (inv_summary(v) & v[B_VE]);
  endfunction

  function automatic logic [POS_W-1:0] field_shift(input logic [FSEL_W-1:0] sel);
    return POS_W'(sel) << $clog2(FLD_W);
  endfunction
endpackage

// File: rtl/fp_status_swpath.sv
module fp_status_swpath
  import fp_status_pkg::*;
(
  input  logic [CSR_W-1:0]  cur,
  input  logic              sw_valid,
  input  logic [2:0]        sw_op,
  input  logic [N_FLD-1:0]  sw_mask,
  input  logic [CSR_W-1:0]  sw_data,
  input  logic [FSEL_W-1:0] sw_fsel,
  input  logic [FLD_W-1:0]  sw_imm,
  input  logic [POS_W-1:0]  sw_pos,
  output logic [CSR_W-1:0]  nxt,
  output logic              copy_hit,
  output logic [FLD_W-1:0]  copy_data
);
  logic [CSR_W-1:0] wmask;
  logic [CSR_W-1:0] sel_mask;
  logic [CSR_W-1:0] pos_mask;
  logic [CSR_W-1:0] aligned;
  logic [POS_W-1:0] shamt;

  // Expand the per-field write mask to bit granularity.
  for (genvar k = 0; k < N_FLD; k++) begin : g_fmask
    assign wmask[CSR_W-1-FLD_W*k -: FLD_W] = {FLD_W{sw_mask[k]}};
  end

  assign shamt     = field_shift(sw_fsel);
  assign sel_mask  = TOP_FIELD >> shamt;
  assign pos_mask  = TOP_BIT >> sw_pos;
  assign aligned   = cur << shamt;
  assign copy_data = aligned[CSR_W-1 -: FLD_W];

  always_comb begin
    nxt      = cur;
    copy_hit = 1'b0;
    if (sw_valid) begin
      case (sw_op_e'(sw_op))
        OP_FIELDS: nxt = (cur & ~wmask) | (sw_data & wmask);
        OP_IMM:    nxt = (cur & ~sel_mask) |
                         ({sw_imm, {(CSR_W-FLD_W){1'b0}}} >> shamt);
        OP_CLR:    nxt = cur & ~pos_mask;
        OP_SET:    nxt = cur | pos_mask;
        OP_COPY: begin
          copy_hit = 1'b1;
          nxt      = cur & ~(sel_mask & M_CLEAR);
        end
        default:   nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/fp_status_merge.sv
module fp_status_merge
  import fp_status_pkg::*;
(
  input  logic [CSR_W-1:0] base,
  input  logic             fpu_valid,
  input  logic [CSR_W-1:0] fpu_flags,
  input  logic [CLS_W-1:0] fpu_class,
  input  logic             fpu_fr,
  input  logic             fpu_fi,
  output logic [CSR_W-1:0] nxt,
  output logic             new_flag
);
  logic [CSR_W-1:0] raised;

  assign raised   = fpu_valid ? (fpu_flags & M_STICKY) : '0;
  assign new_flag = |(raised & ~base);

  always_comb begin
    nxt = base | raised;
    if (fpu_valid) begin
      nxt[B_FR]                  = fpu_fr;
      nxt[B_FI]                  = fpu_fi;
      nxt[B_CLS -: CLS_W]        = fpu_class;
    end
    nxt[B_ANY] = nxt[B_ANY] | new_flag;
    nxt[B_RSV] = 1'b0;
    nxt[B_INV] = inv_summary(nxt);
    nxt[B_EN]  = en_summary(nxt);
  end
endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
  import fp_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fpu_valid,
  input  logic [CSR_W-1:0]  fpu_flags,
  input  logic [CLS_W-1:0]  fpu_class,
  input  logic              fpu_fr,
  input  logic              fpu_fi,
  input  logic              sw_valid,
  input  logic [2:0]        sw_op,
  input  logic [N_FLD-1:0]  sw_mask,
  input  logic [CSR_W-1:0]  sw_data,
  input  logic [FSEL_W-1:0] sw_fsel,
  input  logic [FLD_W-1:0]  sw_imm,
  input  logic [POS_W-1:0]  sw_pos,
  output logic [CSR_W-1:0]  csr_o,
  output logic              exc_req,
  output logic              rd_valid,
  output logic [FLD_W-1:0]  rd_data
);
  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] sw_result;
  logic [CSR_W-1:0] final_val;
  logic             copy_hit;
  logic [FLD_W-1:0] copy_data;
  logic             raised_new;
  logic             req_q;
  logic             rdv_q;
  logic [FLD_W-1:0] rdd_q;

  // Software operation first, then the FPU report on top of it.
  fp_status_swpath u_sw (
    .cur       (csr_q),
    .sw_valid  (sw_valid),
    .sw_op     (sw_op),
    .sw_mask   (sw_mask),
    .sw_data   (sw_data),
    .sw_fsel   (sw_fsel),
    .sw_imm    (sw_imm),
    .sw_pos    (sw_pos),
    .nxt       (sw_result),
    .copy_hit  (copy_hit),
    .copy_data (copy_data)
  );

  fp_status_merge u_merge (
    .base      (sw_result),
    .fpu_valid (fpu_valid),
    .fpu_flags (fpu_flags),
    .fpu_class (fpu_class),
    .fpu_fr    (fpu_fr),
    .fpu_fi    (fpu_fi),
    .nxt       (final_val),
    .new_flag  (raised_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
      req_q <= 1'b0;
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      csr_q <= final_val;
      req_q <= final_val[B_EN];
      rdv_q <= copy_hit;
      rdd_q <= copy_hit ? copy_data : rdd_q;
    end
  end

  assign csr_o    = csr_q;
  assign exc_req  = req_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  a_r3_new_sets_any: assert property (@(posedge clk) disable iff (!rst_n)
    raised_new |=> csr_q[B_ANY]);
  a_r4_inv_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[B_INV] == |(csr_q & M_INV));
  a_r5_req_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req == csr_q[B_EN]);
  a_r8_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[B_RSV] == 1'b0);
  a_r9_copy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_op == OP_COPY) |=> rd_valid);
  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_valid |=> (($past(csr_q) & M_CLEAR & ~csr_q) == '0));
endmodule

// File: tb/sim_fp_status_ctl.sv
`timescale 1ns/100ps
module sim_fp_status_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fpu_valid = 1'b0;
  logic [31:0] fpu_flags = '0;
  logic [4:0]  fpu_class = '0;
  logic        fpu_fr = 1'b0, fpu_fi = 1'b0;
  logic        sw_valid = 1'b0;
  logic [2:0]  sw_op = '0;
  logic [7:0]  sw_mask = '0;
  logic [31:0] sw_data = '0;
  logic [2:0]  sw_fsel = '0;
  logic [3:0]  sw_imm = '0;
  logic [4:0]  sw_pos = '0;
  logic [31:0] csr_o;
  logic        exc_req, rd_valid;
  logic [3:0]  rd_data;

  int n_run = 0, n_fail = 0;
  logic [31:0] mdl = '0;

  typedef struct {
    logic [31:0] csr;
    logic        req;
    logic        rv;
    logic [3:0]  rd;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  fp_status_ctl u0 (
    .clk(clk), .rst_n(rst_n), .fpu_valid(fpu_valid), .fpu_flags(fpu_flags),
    .fpu_class(fpu_class), .fpu_fr(fpu_fr), .fpu_fi(fpu_fi),
    .sw_valid(sw_valid), .sw_op(sw_op), .sw_mask(sw_mask), .sw_data(sw_data),
    .sw_fsel(sw_fsel), .sw_imm(sw_imm), .sw_pos(sw_pos),
    .csr_o(csr_o), .exc_req(exc_req), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [31:0] pb(input int p);
    return 32'h8000_0000 >> p;
  endfunction
  function automatic bit is_flag(input int p);
    return (p >= 3 && p <= 12) || (p >= 21 && p <= 23);
  endfunction
  function automatic bit is_inv(input int p);
    return (p >= 7 && p <= 12) || (p >= 21 && p <= 23);
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit fv, input logic [31:0] fx, input logic [4:0] fc,
                      input bit ffr, input bit ffi, input bit sv,
                      input logic [2:0] op, input logic [7:0] mk,
                      input logic [31:0] dt, input logic [2:0] fs,
                      input logic [3:0] im, input logic [4:0] bp, input string tag);
    logic [31:0] m;
    bit rv, nw, vx;
    logic [3:0] rd;
    item_t it;
    @(negedge clk);
    fpu_valid = fv; fpu_flags = fx; fpu_class = fc; fpu_fr = ffr; fpu_fi = ffi;
    sw_valid = sv; sw_op = op; sw_mask = mk; sw_data = dt; sw_fsel = fs;
    sw_imm = im; sw_pos = bp;
    m = mdl; rv = 0; nw = 0; rd = 4'h0;
    if (sv) begin
      case (op)
        3'd0: for (int k = 0; k < 8; k++)
                if (mk[k]) for (int j = 0; j < 4; j++) m[31-(4*k+j)] = dt[31-(4*k+j)];
        3'd1: for (int j = 0; j < 4; j++) m[31-(4*fs+j)] = im[3-j];
        3'd2: m[31-bp] = 1'b0;
        3'd3: m[31-bp] = 1'b1;
        3'd4: begin
          rv = 1;
          for (int j = 0; j < 4; j++) begin
            rd[3-j] = m[31-(4*fs+j)];
            if (4*fs+j == 0 || is_flag(4*fs+j)) m[31-(4*fs+j)] = 1'b0;
          end
        end
        default: ;
      endcase
    end
    if (fv) begin
      for (int p = 0; p < 32; p++)
        if (is_flag(p) && fx[31-p]) begin
          if (!m[31-p]) nw = 1;
          m[31-p] = 1'b1;
        end
      m[31-13] = ffr; m[31-14] = ffi;
      for (int j = 0; j < 5; j++) m[31-(15+j)] = fc[4-j];
    end
    if (nw) m[31] = 1'b1;
    m[31-20] = 1'b0;
    vx = 0;
    for (int p = 0; p < 32; p++) if (is_inv(p) && m[31-p]) vx = 1;
    m[31-2] = vx;
    m[31-1] = (m[31-3] & m[31-25]) | (m[31-4] & m[31-26]) | (m[31-5] & m[31-27]) |
              (m[31-6] & m[31-28]) | (vx & m[31-24]);
    mdl = m;
    it.csr = m; it.req = m[31-1]; it.rv = rv; it.rd = rd; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rep(input logic [31:0] fx, input logic [4:0] fc, input string tag);
    step(1, fx, fc, 1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic bset(input int p, input string tag);
    step(0, 0, 0, 0, 0, 1, 3'd3, 0, 0, 0, 0, 5'(p), tag);
  endtask
  task automatic bclr(input int p, input string tag);
    step(0, 0, 0, 0, 0, 1, 3'd2, 0, 0, 0, 0, 5'(p), tag);
  endtask
  task automatic copy(input int f, input string tag);
    step(0, 0, 0, 0, 0, 1, 3'd4, 0, 0, 3'(f), 0, 0, tag);
  endtask

  // Monitor: compares each queued item just after the edge that produced it.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      n_run++;
      if (csr_o !== e.csr || exc_req !== e.req || rd_valid !== e.rv ||
          (e.rv && rd_data !== e.rd)) begin
        n_fail++;
        $display("FAIL %s csr=%h req=%b rv=%b rd=%h expected csr=%h req=%b rv=%b rd=%h",
                 e.tag, csr_o, exc_req, rd_valid, rd_data, e.csr, e.req, e.rv, e.rd);
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (csr_o !== 32'h0 || exc_req !== 1'b0 || rd_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 csr=%h req=%b rv=%b expected 0 0 0", csr_o, exc_req, rd_valid);
    end
    rst_n = 1'b1;
    idle("R1");
    rep(pb(3), 5'h11, "R2 R3 overflow report");
    idle("R11 hold");
    bclr(0, "R8 clear summary bit alone");
    rep(pb(3), 5'h02, "R3 repeat flag no new transition");
    bset(25, "R5 enable overflow");
    bclr(25, "R5 disable overflow");
    rep(pb(7) | pb(22), 5'h04, "R4 invalid flags");
    bset(24, "R5 invalid enable");
    bset(1, "R8 write enabled summary ignored");
    bclr(2, "R8 write invalid summary ignored");
    bset(20, "R8 reserved ignored");
    step(0, 0, 0, 0, 0, 1, 3'd0, 8'hC0, 32'h0000_00A7, 0, 0, 0, "R6 masked field write");
    step(0, 0, 0, 0, 0, 1, 3'd0, 8'h01, 32'h6000_0000, 0, 0, 0, "R6 field 0 write");
    step(0, 0, 0, 0, 0, 1, 3'd1, 0, 0, 3'd7, 4'b0010, 0, "R7 immediate write");
    step(0, 0, 0, 0, 0, 1, 3'd1, 0, 0, 3'd1, 4'b1111, 0, "R7 immediate flags");
    step(0, 0, 0, 0, 0, 1, 3'd6, 8'hFF, 32'hFFFF_FFFF, 0, 0, 0, "R8 unused code");
    copy(0, "R9 copy field 0");
    copy(1, "R9 copy field 1");
    copy(6, "R9 copy enables untouched");
    rep(pb(4), 5'h08, "R2 underflow");
    step(1, pb(4), 5'h03, 0, 1, 1, 3'd2, 0, 0, 0, 0, 5'd4, "R10 clear and report same cycle");
    step(1, pb(5), 5'h01, 1, 1, 1, 3'd4, 0, 0, 3'd1, 0, 0, "R10 copy and report same cycle");
    repeat (4) idle("R11 hold");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom % 6);
      step($urandom % 2, $urandom & $urandom & $urandom, 5'($urandom), $urandom % 2,
           $urandom % 2, $urandom % 2, op, 8'($urandom), $urandom, 3'($urandom),
           4'($urandom), 5'($urandom), "R10 mixed traffic");
    end
    idle("R11 drain");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule